// File: doc/BRIEF.md
# Paged Write Collector with Timed Commit

This block sits between the serial protocol engine of a small non-volatile memory and its storage array. At the start of a write transaction the engine hands it the starting word address; every data byte that follows is written into a small page buffer. Each byte goes to the slot picked by the low address bits, and only those low bits advance after each byte, so the page never changes during a transaction. Nothing is sent to the array while bytes arrive.

When the engine reports a STOP and at least one byte has been collected, the block starts one self-timed programming cycle. A cycle counter holds `busy` high for a fixed number of system clocks. During the first clocks of that window the collected bytes are written to the array in ascending slot order. While `busy` is high every input from the engine is ignored. When the cycle ends, the slot marks are cleared. The block also returns the address the read counter should take after the write: the address that follows the last byte written, using the same in-page wrap.

Top module: `page_write_engine`

## Requirements
- R1: `PAGE_BYTES` sets the page to 8 or 16 bytes. The low log2(`PAGE_BYTES`) address bits form the in-page index, and the remaining high bits form the page number.
- R2: When `addrLoad` is accepted, the page number and in-page index are taken from `startAddr`. Each accepted `byteValid` stores `byteData` at the current index. The index then increments by one modulo `PAGE_BYTES`, and the page number never changes.
- R3: If more than `PAGE_BYTES` bytes arrive before STOP, the index wraps and later bytes replace earlier ones. Each array location receives the most recent byte sent to it, and it is written once per commit.
- R4: `arrWrEn` is never high while `busy` is low, so nothing reaches the array before STOP.
- R5: A `stopSeen` pulse accepted with at least one collected byte raises `busy` on the next clock. `busy` then stays high for exactly `WR_CYCLES` clock cycles.
- R6: During a commit, only slots that received a byte in the transaction are written. The writes occur in ascending slot order within the first `PAGE_BYTES` cycles of `busy`. Every write address lies in the transaction's page.
- R7: A `stopSeen` pulse with no collected byte leaves `busy` low and produces no array write.
- R8: While `busy` is high, `addrLoad`, `byteValid` and `stopSeen` have no effect.
- R9: `nextAddr` equals the page number joined with the current in-page index. This is `startAddr` right after a load, and after N bytes it is the start index plus N modulo `PAGE_BYTES`. It holds its value through the commit.
- R10: An accepted `addrLoad` discards any bytes collected but not yet committed.
- R11: After reset, `busy` and `arrWrEn` are low and `nextAddr` is zero.
- R12: The slot marks are cleared when `busy` falls, so a later transaction writes only its own bytes.
- R13: When several controls are high in one cycle, `addrLoad` wins over `stopSeen`, and `stopSeen` wins over `byteValid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| startAddr | input | ADDR_W | Word address at which the transaction starts |
| addrLoad | input | 1 | Strobe that loads `startAddr` and opens a new transaction |
| byteValid | input | 1 | Strobe that marks `byteData` as a received data byte |
| byteData | input | 8 | Received data byte |
| stopSeen | input | 1 | Pulse that reports a STOP condition |
| busy | output | 1 | High during the self-timed programming cycle |
| arrWrEn | output | 1 | Array write enable |
| arrWrAddr | output | ADDR_W | Array write address |
| arrWrData | output | 8 | Array write data |
| nextAddr | output | ADDR_W | Address to hand back to the read counter |

## Verification
Stimulus is driven on falling edges, and every result is sampled two time units after a later falling edge. A load or byte accepted at a rising edge shows up on `nextAddr` at the next falling edge. `busy` is checked at the first falling edge after the STOP edge, and from there it is counted high for exactly `WR_CYCLES` falling edges. The array writes come from registered state, so a monitor captures them on falling edges into a model array. That model array is compared with an arithmetically built expected image once `busy` has dropped, together with the write count and the write order.

// File: rtl/pgwr_pkg.sv
package pgwr_pkg;

  // Strobes from the control module to the datapath
  typedef struct packed {
    logic loadAddr;   // take a new start address
    logic storeByte;  // put a byte into the current slot
    logic launch;     // programming cycle starts at this edge
    logic clearMask;  // drop all slot marks
    logic commitOn;   // commit phase: present the current slot on the array port
  } pgwrCtl_t;

endpackage

// File: rtl/pgwr_ctrl.sv
module pgwr_ctrl
  import pgwr_pkg::*;
#(
  parameter int PAGE_BYTES = 16,
  parameter int WR_CYCLES  = 250000
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          addrLoad,
  input  logic                          byteValid,
  input  logic                          stopSeen,
  input  logic                          maskAny,
  output logic                          busy,
  output pgwrCtl_t                      ctl,
  output logic [$clog2(PAGE_BYTES)-1:0] slotIdx
);
  localparam int PG_W  = $clog2(PAGE_BYTES);
  localparam int CNT_W = $clog2(WR_CYCLES + 1);
  localparam logic [CNT_W-1:0] LAST_CNT   = CNT_W'(WR_CYCLES - 1);
  localparam logic [CNT_W-1:0] COMMIT_END = CNT_W'(PAGE_BYTES);

  logic [CNT_W-1:0] cycCnt;
  logic             idle;
  logic             lastTick;

  always_comb begin
    idle          = !busy;
    lastTick      = busy && (cycCnt == LAST_CNT);
    ctl.loadAddr  = idle && addrLoad;
    ctl.launch    = idle && !addrLoad && stopSeen && maskAny;
    ctl.storeByte = idle && !addrLoad && !stopSeen && byteValid;
    ctl.clearMask = ctl.loadAddr || lastTick;
    ctl.commitOn  = busy && (cycCnt < COMMIT_END);
    slotIdx       = cycCnt[PG_W-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy   <= 1'b0;
      cycCnt <= '0;
    end else if (ctl.launch) begin
      busy   <= 1'b1;
      cycCnt <= '0;
    end else if (busy) begin
      if (lastTick) begin
        busy   <= 1'b0;
        cycCnt <= '0;
      end else begin
        cycCnt <= cycCnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/pgwr_datapath.sv
module pgwr_datapath
  import pgwr_pkg::*;
#(
  parameter int ADDR_W     = 11,
  parameter int PAGE_BYTES = 16
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  pgwrCtl_t                      ctl,
  input  logic [$clog2(PAGE_BYTES)-1:0] slotIdx,
  input  logic [ADDR_W-1:0]             startAddr,
  input  logic [7:0]                    byteData,
  output logic                          maskAny,
  output logic                          arrWrEn,
  output logic [ADDR_W-1:0]             arrWrAddr,
  output logic [7:0]                    arrWrData,
  output logic [ADDR_W-1:0]             nextAddr
);
  localparam int PG_W = $clog2(PAGE_BYTES);
  localparam int HI_W = ADDR_W - PG_W;

  logic [HI_W-1:0] pageHi;
  logic [PG_W-1:0] slotPtr;
  logic            slotMark [PAGE_BYTES];
  logic [7:0]      pageBuf  [PAGE_BYTES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pageHi  <= '0;
      slotPtr <= '0;
    end else if (ctl.loadAddr) begin
      pageHi  <= startAddr[ADDR_W-1:PG_W];
      slotPtr <= startAddr[PG_W-1:0];
    end else if (ctl.storeByte) begin
      slotPtr <= slotPtr + 1'b1;  // wraps within the page
    end
  end

  for (genvar s = 0; s < PAGE_BYTES; s++) begin : g_slot
    logic hit;
    assign hit = ctl.storeByte && (slotPtr == PG_W'(s));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)              slotMark[s] <= 1'b0;
      else if (ctl.clearMask) slotMark[s] <= 1'b0;
      else if (hit)           slotMark[s] <= 1'b1;
    end

    always_ff @(posedge clk) begin
      if (hit) pageBuf[s] <= byteData;
    end
  end

  always_comb begin
    maskAny = 1'b0;
    for (int i = 0; i < PAGE_BYTES; i++) maskAny = maskAny | slotMark[i];
  end

  assign arrWrEn   = ctl.commitOn && slotMark[slotIdx];
  assign arrWrAddr = {pageHi, slotIdx};
  assign arrWrData = pageBuf[slotIdx];
  assign nextAddr  = {pageHi, slotPtr};

endmodule

// File: rtl/page_write_engine.sv
module page_write_engine
  import pgwr_pkg::*;
#(
  parameter int ADDR_W     = 11,
  parameter int PAGE_BYTES = 16,      // 8 or 16
  parameter int WR_CYCLES  = 250000   // must be >= PAGE_BYTES
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic              addrLoad,
  input  logic              byteValid,
  input  logic [7:0]        byteData,
  input  logic              stopSeen,
  output logic              busy,
  output logic              arrWrEn,
  output logic [ADDR_W-1:0] arrWrAddr,
  output logic [7:0]        arrWrData,
  output logic [ADDR_W-1:0] nextAddr
);
  localparam int PG_W = $clog2(PAGE_BYTES);

  pgwrCtl_t        ctl;
  logic [PG_W-1:0] slotIdx;
  logic            maskAny;

  pgwr_ctrl #(.PAGE_BYTES(PAGE_BYTES), .WR_CYCLES(WR_CYCLES)) i_ctrl (
    .clk(clk), .rstN(rstN), .addrLoad(addrLoad), .byteValid(byteValid),
    .stopSeen(stopSeen), .maskAny(maskAny), .busy(busy), .ctl(ctl),
    .slotIdx(slotIdx)
  );

  pgwr_datapath #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES)) i_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .slotIdx(slotIdx),
    .startAddr(startAddr), .byteData(byteData), .maskAny(maskAny),
    .arrWrEn(arrWrEn), .arrWrAddr(arrWrAddr), .arrWrData(arrWrData),
    .nextAddr(nextAddr)
  );

endmodule

// File: rtl/page_write_engine_chk.sv
module page_write_engine_chk #(
  parameter int ADDR_W     = 11,
  parameter int PAGE_BYTES = 16,
  parameter int WR_CYCLES  = 250000
) (
  input logic              clk,
  input logic              rstN,
  input logic              stopSeen,
  input logic              busy,
  input logic              arrWrEn,
  input logic [ADDR_W-1:0] arrWrAddr,
  input logic [ADDR_W-1:0] nextAddr
);
  localparam int PG_W = $clog2(PAGE_BYTES);

  logic [31:0] busyLen;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     busyLen <= '0;
    else if (busy) busyLen <= busyLen + 1'b1;
    else           busyLen <= '0;
  end

  assert_wr_in_busy_R4: assert property (@(posedge clk) disable iff (!rstN)
    arrWrEn |-> busy);

  assert_busy_length_R5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> (busyLen == 32'(WR_CYCLES)));

  assert_busy_needs_stop_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(stopSeen));

  assert_wr_in_page_R6: assert property (@(posedge clk) disable iff (!rstN)
    arrWrEn |-> (arrWrAddr[ADDR_W-1:PG_W] == nextAddr[ADDR_W-1:PG_W]));

  assert_addr_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> $stable(nextAddr));

endmodule

bind page_write_engine page_write_engine_chk #(
  .ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES), .WR_CYCLES(WR_CYCLES)
) i_chk (
  .clk(clk), .rstN(rstN), .stopSeen(stopSeen), .busy(busy),
  .arrWrEn(arrWrEn), .arrWrAddr(arrWrAddr), .nextAddr(nextAddr)
);

// File: tb/test_page_write_engine.sv
module test_page_write_engine;
  localparam int AW = 8;
  localparam int PB = 8;
  localparam int WC = 24;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [AW-1:0] startAddr = '0;
  logic          addrLoad = 1'b0;
  logic          byteValid = 1'b0;
  logic [7:0]    byteData = '0;
  logic          stopSeen = 1'b0;
  logic          busy, arrWrEn;
  logic [AW-1:0] arrWrAddr, nextAddr;
  logic [7:0]    arrWrData;

  int errors = 0;
  int checks = 0;
  int wrCount = 0;
  bit orderBad = 0;
  int prevWr = 0;
  int seq = 0;
  logic [7:0] arrModel [1<<AW];
  logic [7:0] expModel [1<<AW];

  always #10 clk = ~clk;  // 50 MHz

  page_write_engine #(.ADDR_W(AW), .PAGE_BYTES(PB), .WR_CYCLES(WC)) i_page_write_engine (
    .clk(clk), .rstN(rstN), .startAddr(startAddr), .addrLoad(addrLoad),
    .byteValid(byteValid), .byteData(byteData), .stopSeen(stopSeen),
    .busy(busy), .arrWrEn(arrWrEn), .arrWrAddr(arrWrAddr),
    .arrWrData(arrWrData), .nextAddr(nextAddr)
  );

  // Storage array model fed from the write port
  always @(negedge clk) begin
    if (rstN && arrWrEn) begin
      if (wrCount > 0 && int'(arrWrAddr) <= prevWr) orderBad = 1;
      prevWr = int'(arrWrAddr);
      wrCount++;
      arrModel[arrWrAddr] = arrWrData;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic settle();
    @(negedge clk);
    #2;
  endtask

  task automatic loadAddr(input int a);
    @(negedge clk);
    startAddr = AW'(a);
    addrLoad  = 1'b1;
    @(negedge clk);
    addrLoad  = 1'b0;
  endtask

  task automatic sendBytes(input int a, input int n);
    for (int k = 0; k < n; k++) begin
      byteValid = 1'b1;
      byteData  = 8'((seq * 37) + (k * 11) + a);
      expModel[(a & ~(PB - 1)) | ((a + k) % PB)] = byteData;
      @(negedge clk);
    end
    byteValid = 1'b0;
  endtask

  // STOP, then measure busy and the commit; expected busy length given
  task automatic stopAndMeasure(input int expBusy, input int expWr, input string tag);
    int hi;
    wrCount  = 0;
    orderBad = 0;
    stopSeen = 1'b1;
    @(negedge clk);
    stopSeen = 1'b0;
    #2;
    chk({tag, " busy after STOP (R5/R7)"}, int'(busy), expBusy > 0 ? 1 : 0);
    hi = 0;
    while (busy && hi < 1000) begin
      hi++;
      settle();
    end
    chk({tag, " busy length (R5)"}, hi, expBusy);
    chk({tag, " write count (R3/R6/R12)"}, wrCount, expWr);
    chk({tag, " ascending order (R6)"}, int'(orderBad), 0);
  endtask

  task automatic checkArray(input string tag);
    int bad;
    bad = 0;
    for (int i = 0; i < (1 << AW); i++) if (arrModel[i] !== expModel[i]) bad++;
    chk({tag, " array image mismatches (R2/R3)"}, bad, 0);
  endtask

  initial begin
    for (int i = 0; i < (1 << AW); i++) begin
      arrModel[i] = '0;
      expModel[i] = '0;
    end
    settle();
    // R11: reset state
    chk("reset busy (R11)", int'(busy), 0);
    chk("reset arrWrEn (R11)", int'(arrWrEn), 0);
    chk("reset nextAddr (R11)", int'(nextAddr), 0);
    @(negedge clk);
    rstN = 1'b1;

    // Sweep start offsets and byte counts (R1, R2, R3, R5, R6, R7, R9)
    for (int off = 0; off < PB; off++) begin
      for (int n = 0; n <= PB + 3; n++) begin
        int base;
        int a;
        base = (off * 3 + n * 5) % ((1 << AW) / PB);
        a    = base * PB + off;
        seq++;
        loadAddr(a);
        sendBytes(a, n);
        #2;
        chk("nextAddr after bytes (R9/R2)", int'(nextAddr), base * PB + ((off + n) % PB));
        stopAndMeasure(n > 0 ? WC : 0, n > PB ? PB : n, "sweep");
        chk("nextAddr after commit (R9)", int'(nextAddr), base * PB + ((off + n) % PB));
        checkArray("sweep");
      end
    end

    // R8/R12: inputs during busy are ignored, marks cleared afterwards
    seq++;
    loadAddr(8'h12);
    sendBytes(8'h12, 2);
    wrCount  = 0;
    orderBad = 0;
    stopSeen = 1'b1;
    @(negedge clk);
    stopSeen  = 1'b0;
    startAddr = 8'hA3;
    addrLoad  = 1'b1;
    @(negedge clk);
    addrLoad  = 1'b0;
    byteValid = 1'b1;
    byteData  = 8'h5A;
    @(negedge clk);
    byteValid = 1'b0;
    stopSeen  = 1'b1;
    @(negedge clk);
    stopSeen  = 1'b0;
    while (busy) @(negedge clk);
    #2;
    chk("load during busy ignored (R8)", int'(nextAddr), 8'h14);
    chk("commit writes (R8)", wrCount, 2);
    checkArray("busy-ignore R8");
    stopAndMeasure(0, 0, "byte during busy ignored R8/R12");

    // R10: a new load drops uncommitted bytes
    seq++;
    loadAddr(8'h30);
    begin
      logic [7:0] keep [1<<AW];
      for (int i = 0; i < (1 << AW); i++) keep[i] = expModel[i];
      sendBytes(8'h30, 3);
      for (int i = 0; i < (1 << AW); i++) expModel[i] = keep[i];
    end
    loadAddr(8'h57);
    #2;
    chk("nextAddr after reload (R10/R9)", int'(nextAddr), 8'h57);
    stopAndMeasure(0, 0, "reload R10");
    checkArray("reload R10");

    // R13: addrLoad wins over stopSeen and byteValid in the same cycle
    seq++;
    loadAddr(8'h60);
    sendBytes(8'h60, 1);
    @(negedge clk);
    startAddr = 8'h68;
    addrLoad  = 1'b1;
    stopSeen  = 1'b1;
    byteValid = 1'b1;
    @(negedge clk);
    addrLoad  = 1'b0;
    stopSeen  = 1'b0;
    byteValid = 1'b0;
    #2;
    chk("load beats STOP (R13)", int'(busy), 0);
    chk("load beats byte (R13)", int'(nextAddr), 8'h68);
    expModel[8'h60] = arrModel[8'h60];  // byte was discarded by the load
    // stopSeen beats byteValid: byte not stored, commit holds one byte
    seq++;
    sendBytes(8'h68, 1);
    wrCount  = 0;
    orderBad = 0;
    stopSeen  = 1'b1;
    byteValid = 1'b1;
    byteData  = 8'hEE;
    @(negedge clk);
    stopSeen  = 1'b0;
    byteValid = 1'b0;
    while (busy) @(negedge clk);
    #2;
    chk("STOP beats byte, writes (R13)", wrCount, 1);
    chk("STOP beats byte, ptr (R13)", int'(nextAddr), 8'h69);
    checkArray("priority R13");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule